// File: doc/BRIEF.md
# Multi-Cycle 16-bit Register Processor Core

This block is a small 16-bit processor core built around a control state machine that runs each instruction over several clock cycles. It holds an 8-bit program counter, an instruction register, a bank of sixteen 16-bit general-purpose registers and four status flags. It talks to a word-addressed external memory through a registered address register and a registered store-data register. Instruction and data words share the same memory.

Each instruction word carries a 4-bit operation field in bits 15:12, a register field in bits 11:8 and an 8-bit field in bits 7:0. Depending on the operation, the 8-bit field is a memory address, an immediate value, or a second register index taken from bits 7:4. A two-bit writeback select routes one of three sources into the register bank: the ALU result, the memory read word, or the zero-extended immediate. The fourth select code writes nothing.

Top module: `mc_core`

## Requirements
- R1: Every instruction passes through the states fetch, PC-increment, decode and execute in that order. ALU, immediate-load, unassigned and halt instructions take 4 cycles. A store takes 5 cycles and a load takes 6 cycles.
- R2: Operation codes are 0 ADD, 1 SUB, 2 AND, 3 OR, 4 XOR, 8 LOAD, 9 STORE, A LOADIMM and F HALT. An ALU instruction computes reg[11:8] = reg[11:8] op reg[7:4] and writes the result back to reg[11:8].
- R3: The flags output is {zero, negative, carry, overflow} in bits 3..0. Carry is the carry out of a+b for ADD and of a+~b+1 for SUB; it is 0 for logic operations. Overflow is signed overflow for ADD and SUB and 0 otherwise. The flags change only when an ALU instruction executes.
- R4: LOADIMM writes the 8-bit field into reg[11:8], zero-extended to 16 bits.
- R5: LOAD and STORE place bits 7:0 of the instruction on mem_addr. A STORE drives mem_we for one cycle, with mem_wdata equal to reg[11:8]. The memory must return mem_rdata one cycle after any cycle in which mem_re is high. The fetch address comes from the PC.
- R6: Register writeback uses select codes 00 ALU, 01 memory, 10 immediate and 11 none. Select 11 never writes. At most one register is written per cycle. Unassigned operation codes change no register, flag or memory word.
- R7: HALT stops the state machine. After a HALT, pc, flags and registers hold, and mem_re and mem_we stay low until reset.
- R8: The PC increments once per instruction and wraps from 255 to 0.
- R9: Synchronous active-high reset clears the PC, the flags and all sixteen registers, deasserts mem_re and mem_we, and enters the fetch state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Registered memory address |
| mem_re | output | 1 | Registered memory read strobe |
| mem_we | output | 1 | Registered memory write strobe |
| mem_wdata | output | 16 | Registered store data |
| mem_rdata | input | 16 | Memory read word, valid one cycle after mem_re |
| pc | output | 8 | Program counter |
| flags | output | 4 | {zero, negative, carry, overflow} |
| halted | output | 1 | High once a HALT has executed |

## Verification
The program adds 0x7F to a zero-extended 0x81. A sign-extending immediate would give 0x0000 here instead of 0x0100. Other additions are chosen to wrap to zero and to cross into the sign bit, and a wrong carry or overflow rule shows up in the stored sums and in the final flags. A subtraction that borrows, followed by an immediate load, checks the carry polarity and that the flags stay put: a design that updates flags on non-ALU instructions ends with the zero flag set. A store of register 0 checks the reset clear. An unassigned operation with non-zero fields must leave a register unchanged, and a core that halts late or writes to memory after HALT is caught by the write scoreboard and by the cycle count. A program of unassigned words runs the PC past 255, and it must read 0 next.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_INC    = 3'd1,
    ST_DECODE = 3'd2,
    ST_EXEC   = 3'd3,
    ST_MEM    = 3'd4,
    ST_LDWB   = 3'd5,
    ST_HALT   = 3'd6
  } ctl_state_t;

  typedef enum logic [1:0] {
    WB_ALU  = 2'b00,
    WB_MEM  = 2'b01,
    WB_IMM  = 2'b10,
    WB_NONE = 2'b11
  } wb_sel_t;

  localparam logic [3:0] OP_ADD   = 4'h0;
  localparam logic [3:0] OP_SUB   = 4'h1;
  localparam logic [3:0] OP_AND   = 4'h2;
  localparam logic [3:0] OP_OR    = 4'h3;
  localparam logic [3:0] OP_XOR   = 4'h4;
  localparam logic [3:0] OP_LOAD  = 4'h8;
  localparam logic [3:0] OP_STORE = 4'h9;
  localparam logic [3:0] OP_LDI   = 4'hA;
  localparam logic [3:0] OP_HALT  = 4'hF;

endpackage

// File: rtl/mc_alu.sv
module mc_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [3:0]    op,
  output logic [DW-1:0] y,
  output logic [3:0]    fl
);
  import mc_pkg::*;

  logic [DW:0] sum_ext;
  logic        cout;
  logic        ovf;

  always_comb begin
    sum_ext = '0;
    cout    = 1'b0;
    ovf     = 1'b0;
    unique case (op)
      OP_ADD: begin
        sum_ext = {1'b0, a} + {1'b0, b};
        y       = sum_ext[DW-1:0];
        cout    = sum_ext[DW];
        ovf     = (a[DW-1] == b[DW-1]) && (y[DW-1] != a[DW-1]);
      end
      OP_SUB: begin
        sum_ext = {1'b0, a} + {1'b0, ~b} + {{DW{1'b0}}, 1'b1};
        y       = sum_ext[DW-1:0];
        cout    = sum_ext[DW];
        ovf     = (a[DW-1] != b[DW-1]) && (y[DW-1] != a[DW-1]);
      end
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = '0;
    endcase
    fl = {(y == '0), y[DW-1], cout, ovf};
  end

endmodule

// File: rtl/mc_wbsel.sv
module mc_wbsel #(
  parameter int DW = 16
) (
  input  mc_pkg::wb_sel_t sel,
  input  logic [DW-1:0]   alu_y,
  input  logic [DW-1:0]   mem_y,
  input  logic [DW-1:0]   imm_y,
  output logic [DW-1:0]   wd,
  output logic            wd_valid
);
  import mc_pkg::*;

  always_comb begin
    wd       = '0;
    wd_valid = 1'b1;
    unique case (sel)
      WB_ALU:  wd = alu_y;
      WB_MEM:  wd = mem_y;
      WB_IMM:  wd = imm_y;
      default: wd_valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] wa,
  input  logic [DW-1:0]           wd,
  input  logic [$clog2(NREG)-1:0] ra,
  input  logic [$clog2(NREG)-1:0] rb,
  output logic [DW-1:0]           rda,
  output logic [DW-1:0]           rdb
);
  localparam int RW = $clog2(NREG);

  logic [DW-1:0]   bank [NREG];
  logic [NREG-1:0] wr_hot;

  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign wr_hot[g] = we && (wa == RW'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)            bank[i] <= '0;
      else if (wr_hot[i]) bank[i] <= wd;
    end
  end

  assign rda = bank[ra];
  assign rdb = bank[rb];

  // R6
  wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_hot) && (we == (wr_hot != '0)));

endmodule

// File: rtl/mc_core.sv
module mc_core #(
  parameter int DW   = 16,
  parameter int AW   = 8,
  parameter int NREG = 16
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] pc,
  output logic [3:0]    flags,
  output logic          halted
);
  import mc_pkg::*;

  localparam int RW = $clog2(NREG);

  ctl_state_t    state;
  logic [DW-1:0] ir;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] mar_q;
  logic [DW-1:0] mdr_q;
  logic          re_q;
  logic          we_q;
  logic [3:0]    flags_q;

  logic [3:0]    opc;
  logic [RW-1:0] rd_idx;
  logic [RW-1:0] rs_idx;
  logic [AW-1:0] fld;
  logic [DW-1:0] imm_ext;
  logic          is_alu;

  assign opc     = ir[DW-1 -: 4];
  assign rd_idx  = ir[DW-5 -: RW];
  assign rs_idx  = ir[AW-1 -: RW];
  assign fld     = ir[AW-1:0];
  assign imm_ext = {{(DW-AW){1'b0}}, fld};
  assign is_alu  = (opc <= OP_XOR);

  logic [DW-1:0] opa, opb, alu_y, wd;
  logic [3:0]    alu_fl;
  logic          wd_valid;
  logic          wb_req;
  wb_sel_t       wb_sel;

  always_comb begin
    wb_req = 1'b0;
    wb_sel = WB_NONE;
    if (state == ST_EXEC && is_alu) begin
      wb_req = 1'b1;
      wb_sel = WB_ALU;
    end else if (state == ST_EXEC && opc == OP_LDI) begin
      wb_req = 1'b1;
      wb_sel = WB_IMM;
    end else if (state == ST_LDWB) begin
      wb_req = 1'b1;
      wb_sel = WB_MEM;
    end
  end

  mc_alu #(.DW(DW)) u_alu (
    .a(opa), .b(opb), .op(opc), .y(alu_y), .fl(alu_fl)
  );

  mc_wbsel #(.DW(DW)) u_wbsel (
    .sel(wb_sel), .alu_y(alu_y), .mem_y(mem_rdata), .imm_y(imm_ext),
    .wd(wd), .wd_valid(wd_valid)
  );

  mc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst), .we(wb_req && wd_valid), .wa(rd_idx), .wd(wd),
    .ra(rd_idx), .rb(rs_idx), .rda(opa), .rdb(opb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_FETCH;
      ir      <= '0;
      pc_q    <= '0;
      mar_q   <= '0;
      mdr_q   <= '0;
      re_q    <= 1'b0;
      we_q    <= 1'b0;
      flags_q <= '0;
    end else begin
      unique case (state)
        ST_FETCH: begin
          mar_q <= pc_q;
          re_q  <= 1'b1;
          state <= ST_INC;
        end
        ST_INC: begin
          re_q  <= 1'b0;
          pc_q  <= pc_q + 1'b1;
          state <= ST_DECODE;
        end
        ST_DECODE: begin
          ir    <= mem_rdata;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          state <= ST_FETCH;
          if (is_alu) begin
            flags_q <= alu_fl;
          end else if (opc == OP_LOAD) begin
            mar_q <= fld;
            re_q  <= 1'b1;
            state <= ST_MEM;
          end else if (opc == OP_STORE) begin
            mar_q <= fld;
            mdr_q <= opa;
            we_q  <= 1'b1;
            state <= ST_MEM;
          end else if (opc == OP_HALT) begin
            state <= ST_HALT;
          end
        end
        ST_MEM: begin
          re_q  <= 1'b0;
          we_q  <= 1'b0;
          state <= (opc == OP_LOAD) ? ST_LDWB : ST_FETCH;
        end
        ST_LDWB: state <= ST_FETCH;
        default: state <= ST_HALT;
      endcase
    end
  end

  assign mem_addr  = mar_q;
  assign mem_re    = re_q;
  assign mem_we    = we_q;
  assign mem_wdata = mdr_q;
  assign pc        = pc_q;
  assign flags     = flags_q;
  assign halted    = (state == ST_HALT);

  // R1
  fetch_then_inc_chk: assert property (@(posedge clk) disable iff (rst)
    state == ST_FETCH |=> state == ST_INC && mem_re && mem_addr == pc);

  // R8
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    state == ST_INC |=> state == ST_DECODE && pc == AW'($past(pc) + 1'b1));

  // R3
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(state == ST_EXEC && is_alu) |=> $stable(flags));

  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(pc) && !mem_re && !mem_we);

  // R5
  store_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> state == ST_MEM && mem_addr == fld && opc == OP_STORE);

  // R6
  none_sel_chk: assert property (@(posedge clk) disable iff (rst)
    wb_sel == WB_NONE |-> !wb_req);

endmodule

// File: tb/sim_mc_core.sv
module sim_mc_core;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  mem_addr;
  logic        mem_re, mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic [7:0]  pc;
  logic [3:0]  flags;
  logic        halted;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_core u0 (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_re(mem_re),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pc(pc), .flags(flags), .halted(halted)
  );

  logic [15:0] mem [256];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  typedef struct {
    logic [7:0]  addr;
    logic [15:0] data;
    string       req;
  } wr_item_t;

  wr_item_t exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_wr(input logic [7:0] a, input logic [15:0] d, input string req);
    wr_item_t it;
    it.addr = a;
    it.data = d;
    it.req  = req;
    exp_q.push_back(it);
  endtask

  // Scoreboard monitor: every memory write must match the next expected store
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected memory write addr", {24'd0, mem_addr}, 32'hffff_ffff);
      end else begin
        wr_item_t it;
        it = exp_q.pop_front();
        chk(mem_addr == it.addr && mem_wdata == it.data, it.req, "store addr/data",
            {8'd0, mem_addr, mem_wdata}, {8'd0, it.addr, it.data});
      end
    end
  end

  task automatic load_program();
    logic [15:0] prog [27];
    prog = '{16'hA17F, 16'hA281, 16'h0120, 16'h91C0, 16'h83D0, 16'hA401,
             16'h0340, 16'h93C1, 16'h90C2, 16'h85D1, 16'h0540, 16'h95C3,
             16'hB5FF, 16'h95C4, 16'hA605, 16'h1640, 16'h96C5, 16'hA73C,
             16'h2760, 16'h3720, 16'h97C6, 16'h4770, 16'h97C7, 16'h1040,
             16'hA900, 16'h90C8, 16'hF000};
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    for (int i = 0; i < 27; i++) mem[i] = prog[i];
    mem[8'hD0] = 16'hFFFF;
    mem[8'hD1] = 16'h7FFF;
  endtask

  initial begin
    int cyc;
    int guard;
    bit stable_ok;
    logic [7:0] pc_hold;

    load_program();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(pc == 8'd0 && flags == 4'd0 && !halted && !mem_we && !mem_re, "R9",
        "reset state {pc,flags,halted,we,re}", {21'd0, pc, flags, halted, mem_we, mem_re}, 32'd0);

    expect_wr(8'hC0, 16'h0100, "R4");  // zero-extended immediate, ADD (R2)
    expect_wr(8'hC1, 16'h0000, "R5");  // loaded 0xFFFF + 1
    expect_wr(8'hC2, 16'h0000, "R9");  // register 0 cleared by reset
    expect_wr(8'hC3, 16'h8000, "R2");  // 0x7FFF + 1
    expect_wr(8'hC4, 16'h8000, "R6");  // unassigned op left r5 alone
    expect_wr(8'hC5, 16'h0004, "R2");  // SUB
    expect_wr(8'hC6, 16'h0085, "R2");  // AND then OR
    expect_wr(8'hC7, 16'h0000, "R2");  // XOR self
    expect_wr(8'hC8, 16'hFFFF, "R2");  // 0 - 1

    rst = 1'b0;
    cyc = 0;
    while (!halted && cyc < 1000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    // R1 cycle budget: 27 instr * 4 + 9 stores * 1 + 2 loads * 2
    chk(cyc == 121, "R1", "cycles to halt", cyc, 32'd121);
    chk(exp_q.size() == 0, "R5", "stores outstanding", exp_q.size(), 32'd0);
    // R3 flags after SUB 0-1, then LOADIMM/STORE/HALT must not touch them
    chk(flags == 4'b0100, "R3", "flags {Z,N,C,V}", {28'd0, flags}, 32'h4);
    chk(pc == 8'd27, "R7", "pc at halt", {24'd0, pc}, 32'd27);
    chk(mem[8'hC0] == 16'h0100, "R4", "memory word C0", {16'd0, mem[8'hC0]}, 32'h0100);

    pc_hold   = pc;
    stable_ok = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pc != pc_hold || !halted || mem_re || mem_we || flags != 4'b0100) stable_ok = 1'b0;
    end
    chk(stable_ok, "R7", "halt holds state", {31'd0, stable_ok}, 32'd1);

    // Phase 2: program of unassigned words, PC wrap
    rst = 1'b1;
    for (int i = 0; i < 256; i++) mem[i] = 16'hB3C4;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(pc == 8'd0 && flags == 4'd0 && !halted, "R9", "second reset",
        {23'd0, pc, halted}, 32'd0);
    rst = 1'b0;
    guard = 0;
    while (pc != 8'd255 && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    chk(pc == 8'd255, "R8", "pc reaches 255", {24'd0, pc}, 32'd255);
    guard = 0;
    while (pc == 8'd255 && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    chk(pc == 8'd0, "R8", "pc wraps to 0", {24'd0, pc}, 32'd0);
    chk(!halted && flags == 4'd0, "R6", "unassigned ops leave flags and run on",
        {27'd0, halted, flags}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule